// File: doc/BRIEF.md
# Super I/O Configuration Access Controller

This block is the configuration front end of a legacy-bus peripheral controller. Software reaches it through two byte-wide I/O ports: an index port that selects a configuration register and a data port that reads or writes it. The pair sits at one of two strap-selected addresses. The configuration space stays locked until a two-write unlock key arrives on the index port. A single exit key on the same port locks it again.

When the space is open, low register offsets are global to the chip. One global register selects the active logical device. Offsets 0x30 and upward are banked per logical device. This block keeps each device's enable byte at offset 0x30 itself. It forwards every higher offset to the attached function block as a one-cycle strobe, carrying the offset and the write data. A read-only chip identity is also available in the global space.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: The index port is at the base address and the data port is at base+1. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Accesses to any other address have no effect and return 0xFF.
- R2: The space opens only after two consecutive index-port writes of 0x87. Any other write to either port between the two key writes returns the sequencer to the locked state.
- R3: While the space is open, an index-port write of 0xAA locks it. The index register is cleared to 0x00 at that point, so after a later unlock the index port reads 0x00.
- R4: While the space is locked, data-port writes change nothing and raise no strobe. Reads of either port return 0xFF.
- R5: Writing a value to the data port while the index is 0x07 selects the logical device, and reading index 0x07 returns it. The selection is 0 after reset and is kept across lock and unlock.
- R6: Index 0x20 reads 0xA2 and index 0x21 reads 0x3 in its upper nibble with the revision parameter in its lower nibble, so the upper 12 bits of the identity are 0xA23. Writes to these indexes are ignored.
- R7: Index 0x30 is the selected device's enable byte. Device d's byte drives `dev_enable[8d+7:8d]` and reads back through the data port. Writing one device's byte leaves the other devices' bytes unchanged and raises no strobe. All enable bytes are 0 after reset.
- R8: With a known device selected (number below NUM_DEV) and an index above 0x30, a data-port write raises bit d of `dev_wr_stb` for exactly one cycle, the cycle after the write. In that cycle `dev_reg_idx` holds the index and `dev_reg_wdata` holds the data. A data-port read returns byte d of `dev_rdata` and pulses `dev_rd_stb[d]` in the same way.
- R9: A read of an unimplemented global index, or of a banked index while the selected device number is NUM_DEV or higher, returns 0x00. A write to such an index has no effect.
- R10: `io_rdata` is registered. It holds the read value in the cycle after a cycle with `io_rd` asserted and 0xFF in every other cycle, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | I/O write cycle |
| io_rd | input | 1 | I/O read cycle |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| dev_rdata | input | NUM_DEV*8 | Banked read data supplied by each function block |
| dev_enable | output | NUM_DEV*8 | Enable byte of each logical device |
| dev_wr_stb | output | NUM_DEV | One-cycle write strobe per device, banked indexes above 0x30 |
| dev_rd_stb | output | NUM_DEV | One-cycle read strobe per device, banked indexes above 0x30 |
| dev_reg_idx | output | 8 | Index of the strobed banked access |
| dev_reg_wdata | output | 8 | Data of the strobed banked write |

## Verification
A sequencer that drifts into the wrong lock state shows at the ports one cycle after the next read. The index port returns 0xFF where the stored index was expected, or the reverse. A corrupted index or device selection shows as a wrong byte in the read that follows. It can also show as a strobe on the wrong `dev_wr_stb` bit, or as a wrong `dev_enable` byte, in the cycle after the write. The stimulus therefore follows every state-changing write with a read or strobe sample before the next change, so that each fault appears within two cycles of its cause.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the configuration access controller.
// Assumes an 8-bit configuration index space and byte-wide data.
package sio_cfg_pkg;

    localparam logic [7:0]  KEY_ENTER  = 8'h87;
    localparam logic [7:0]  KEY_EXIT   = 8'hAA;
    localparam logic [7:0]  IDX_LDN    = 8'h07;
    localparam logic [7:0]  IDX_ID_HI  = 8'h20;
    localparam logic [7:0]  IDX_ID_LO  = 8'h21;
    localparam logic [7:0]  IDX_ENABLE = 8'h30;
    localparam logic [15:0] BASE_LO    = 16'h002E;
    localparam logic [15:0] BASE_HI    = 16'h004E;
    localparam logic [11:0] ID_FAMILY  = 12'hA23;
    localparam logic [7:0]  RD_IDLE    = 8'hFF;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic idx_wr;
        logic data_wr;
        logic idx_rd;
        logic data_rd;
    } port_req_t;

endpackage

// File: rtl/sio_port_decode.sv
// Address decoder for the index/data port pair.
// Assumes io_wr and io_rd are not asserted together; a write wins if they are.
module sio_port_decode
    import sio_cfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output port_req_t         req
);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;
    logic              hit_idx;
    logic              hit_dat;

    // Pick the strapped base and its data-port neighbour.
    always_comb begin
        idx_addr = base_sel ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
        dat_addr = idx_addr + ADDR_W'(1);
    end

    assign hit_idx = (io_addr == idx_addr);
    assign hit_dat = (io_addr == dat_addr);

    // Qualify the port hits with the bus cycle type.
    always_comb begin
        req.idx_wr  = io_wr && hit_idx;
        req.data_wr = io_wr && hit_dat;
        req.idx_rd  = io_rd && !io_wr && hit_idx;
        req.data_rd = io_rd && !io_wr && hit_dat;
    end

endmodule

// File: rtl/sio_key_fsm.sv
// Unlock sequencer: two index-port writes of the enter key open the space,
// and one exit key closes it. Any other port write between keys restarts.
// Assumes a decoded port request from sio_port_decode.
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  port_req_t  req,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       exit_evt
);

    lock_state_e state_q;
    lock_state_e state_d;
    logic        key_in;

    assign key_in   = req.idx_wr && (wdata == KEY_ENTER);
    assign cfg_open = (state_q == LK_OPEN);
    assign exit_evt = cfg_open && req.idx_wr && (wdata == KEY_EXIT);

    // Next-state selection for the key sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            LK_LOCKED: if (key_in) state_d = LK_HALF;
            LK_HALF: begin
                if (key_in)                          state_d = LK_OPEN;
                else if (req.idx_wr || req.data_wr)  state_d = LK_LOCKED;
            end
            LK_OPEN:   if (exit_evt) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // State register, locked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    AST_OPEN_NEEDS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(state_q) == LK_HALF) && $past(key_in)); // R2

    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && req.idx_wr && wdata == KEY_EXIT) |=> !cfg_open); // R3

endmodule

// File: rtl/sio_reg_bank.sv
// Configuration register file: index register, logical-device selector,
// chip identity, per-device enable bytes, forwarding strobes for banked
// indexes above the enable byte, and the registered read-data path.
// Assumes NUM_DEV is at most 255 and that function blocks present their
// banked read data combinationally on dev_rdata.
module sio_reg_bank
    import sio_cfg_pkg::*;
#(
    parameter int         NUM_DEV  = 16,
    parameter logic [3:0] CHIP_REV = 4'h5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  port_req_t            req,
    input  logic [7:0]           wdata,
    input  logic                 cfg_open,
    input  logic                 exit_evt,
    input  logic [NUM_DEV*8-1:0] dev_rdata,
    output logic [7:0]           io_rdata,
    output logic [NUM_DEV*8-1:0] dev_enable,
    output logic [NUM_DEV-1:0]   dev_wr_stb,
    output logic [NUM_DEV-1:0]   dev_rd_stb,
    output logic [7:0]           dev_reg_idx,
    output logic [7:0]           dev_reg_wdata
);

    localparam int          SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [15:0] CHIP_ID = {ID_FAMILY, CHIP_REV};

    logic [7:0]       index_q;
    logic [7:0]       ldn_q;
    logic [SEL_W-1:0] sel;
    logic             dev_known;
    logic             ext_idx;
    logic             en_wr;
    logic             ext_wr;
    logic             ext_rd;
    logic [7:0]       en_q   [NUM_DEV];
    logic [7:0]       dev_rd [NUM_DEV];
    logic [NUM_DEV-1:0] wr_hit;
    logic [NUM_DEV-1:0] rd_hit;
    logic [7:0]       rd_val;

    assign sel       = ldn_q[SEL_W-1:0];
    assign dev_known = (ldn_q < 8'(NUM_DEV));
    assign ext_idx   = (index_q > IDX_ENABLE);
    assign en_wr     = cfg_open && req.data_wr && (index_q == IDX_ENABLE) && dev_known;
    assign ext_wr    = cfg_open && req.data_wr && ext_idx && dev_known;
    assign ext_rd    = cfg_open && req.data_rd && ext_idx && dev_known;

    // Index register: cleared by reset and on leaving configuration mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                        index_q <= 8'h00;
        else if (exit_evt)                 index_q <= 8'h00;
        else if (cfg_open && req.idx_wr)   index_q <= wdata;
    end

    // Logical-device selector, kept across lock and unlock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          ldn_q <= 8'h00;
        else if (cfg_open && req.data_wr && index_q == IDX_LDN) ldn_q <= wdata;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        // Enable byte of device d, written only while it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                              en_q[d] <= 8'h00;
            else if (en_wr && sel == SEL_W'(d))      en_q[d] <= wdata;
        end
        assign dev_enable[d*8 +: 8] = en_q[d];
        assign dev_rd[d]            = dev_rdata[d*8 +: 8];
        assign wr_hit[d]            = ext_wr && (sel == SEL_W'(d));
        assign rd_hit[d]            = ext_rd && (sel == SEL_W'(d));
    end

    // One-cycle strobes toward the function blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_wr_stb <= '0;
            dev_rd_stb <= '0;
        end else begin
            dev_wr_stb <= wr_hit;
            dev_rd_stb <= rd_hit;
        end
    end

    // Offset and data that accompany a forwarded banked access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_reg_idx   <= 8'h00;
            dev_reg_wdata <= 8'h00;
        end else begin
            if (ext_wr || ext_rd) dev_reg_idx   <= index_q;
            if (ext_wr)           dev_reg_wdata <= wdata;
        end
    end

    // Read multiplexer over ports, global registers and the selected bank.
    always_comb begin
        rd_val = 8'h00;
        if (!cfg_open) begin
            rd_val = RD_IDLE;
        end else if (req.idx_rd) begin
            rd_val = index_q;
        end else begin
            case (index_q)
                IDX_LDN:    rd_val = ldn_q;
                IDX_ID_HI:  rd_val = CHIP_ID[15:8];
                IDX_ID_LO:  rd_val = CHIP_ID[7:0];
                IDX_ENABLE: rd_val = dev_known ? en_q[sel] : 8'h00;
                default:    rd_val = (ext_idx && dev_known) ? dev_rd[sel] : 8'h00;
            endcase
        end
    end

    // Registered read data, idle value outside read cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                         io_rdata <= RD_IDLE;
        else if (req.idx_rd || req.data_rd) io_rdata <= rd_val;
        else                                io_rdata <= RD_IDLE;
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_wr_stb) && $onehot0(dev_rd_stb)); // R8

    AST_LOCKED_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_stb != '0) |-> $past(cfg_open)); // R4

    AST_LOCKED_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && (req.idx_rd || req.data_rd)) |=> (io_rdata == RD_IDLE)); // R4

    AST_INDEX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> (index_q == 8'h00)); // R3

    AST_LDN_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(ldn_q)); // R5

    AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && req.data_rd && index_q == IDX_ID_HI) |=> (io_rdata == 8'hA2)); // R6

endmodule

// File: rtl/sio_cfg_ctrl.sv
// Top of the configuration access controller: port decode, key sequencer
// and register bank. Assumes one bus cycle per clock, with io_wr and io_rd
// each held for one cycle per access.
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NUM_DEV  = 16,
    parameter logic [3:0] CHIP_REV = 4'h5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_sel,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [NUM_DEV*8-1:0] dev_rdata,
    output logic [NUM_DEV*8-1:0] dev_enable,
    output logic [NUM_DEV-1:0]   dev_wr_stb,
    output logic [NUM_DEV-1:0]   dev_rd_stb,
    output logic [7:0]           dev_reg_idx,
    output logic [7:0]           dev_reg_wdata
);

    port_req_t req;
    logic      cfg_open;
    logic      exit_evt;

    sio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .base_sel (base_sel),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .req      (req)
    );

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .exit_evt (exit_evt)
    );

    sio_reg_bank #(.NUM_DEV(NUM_DEV), .CHIP_REV(CHIP_REV)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .wdata         (io_wdata),
        .cfg_open      (cfg_open),
        .exit_evt      (exit_evt),
        .dev_rdata     (dev_rdata),
        .io_rdata      (io_rdata),
        .dev_enable    (dev_enable),
        .dev_wr_stb    (dev_wr_stb),
        .dev_rd_stb    (dev_rd_stb),
        .dev_reg_idx   (dev_reg_idx),
        .dev_reg_wdata (dev_reg_wdata)
    );

endmodule

// File: tb/tb_sio_cfg_ctrl.sv
module tb_sio_cfg_ctrl;

    localparam int NUM_DEV = 16;
    localparam logic [1:0] WI = 2'd0, WD = 2'd1, RI = 2'd2, RD = 2'd3;

    function automatic logic [21:0] mk(logic [1:0] op, logic [7:0] d, logic [7:0] e, logic [3:0] r);
        return {op, d, e, r};
    endfunction

    localparam int NV = 53;
    localparam logic [21:0] VEC [NV] = '{
        mk(RI,8'h00,8'hFF,4'd4), mk(RD,8'h00,8'hFF,4'd4), mk(WD,8'h05,8'h00,4'd4),
        mk(WI,8'h87,8'h00,4'd2), mk(WI,8'h12,8'h00,4'd2), mk(WI,8'h87,8'h00,4'd2),
        mk(WD,8'h33,8'h00,4'd2), mk(RI,8'h00,8'hFF,4'd2), mk(WI,8'h87,8'h00,4'd2),
        mk(WI,8'h87,8'h00,4'd2), mk(RI,8'h00,8'h00,4'd2), mk(WI,8'h20,8'h00,4'd6),
        mk(RD,8'h00,8'hA2,4'd6), mk(WI,8'h21,8'h00,4'd6), mk(RD,8'h00,8'h35,4'd6),
        mk(WD,8'h00,8'h00,4'd6), mk(RD,8'h00,8'h35,4'd6), mk(WI,8'h07,8'h00,4'd5),
        mk(RD,8'h00,8'h00,4'd5), mk(WD,8'h03,8'h00,4'd5), mk(RD,8'h00,8'h03,4'd5),
        mk(RI,8'h00,8'h07,4'd5), mk(WI,8'h30,8'h00,4'd7), mk(WD,8'h5A,8'h00,4'd7),
        mk(RD,8'h00,8'h5A,4'd7), mk(WI,8'h07,8'h00,4'd7), mk(WD,8'h04,8'h00,4'd7),
        mk(WI,8'h30,8'h00,4'd7), mk(RD,8'h00,8'h00,4'd7), mk(WI,8'h40,8'h00,4'd8),
        mk(RD,8'h00,8'hA4,4'd8), mk(WI,8'h25,8'h00,4'd9), mk(RD,8'h00,8'h00,4'd9),
        mk(WD,8'h77,8'h00,4'd9), mk(RD,8'h00,8'h00,4'd9), mk(WI,8'h07,8'h00,4'd9),
        mk(WD,8'h20,8'h00,4'd9), mk(WI,8'h30,8'h00,4'd9), mk(RD,8'h00,8'h00,4'd9),
        mk(WI,8'h41,8'h00,4'd9), mk(RD,8'h00,8'h00,4'd9), mk(WI,8'h07,8'h00,4'd7),
        mk(WD,8'h03,8'h00,4'd7), mk(WI,8'h30,8'h00,4'd7), mk(RD,8'h00,8'h5A,4'd7),
        mk(WI,8'hAA,8'h00,4'd3), mk(RD,8'h00,8'hFF,4'd3), mk(RI,8'h00,8'hFF,4'd3),
        mk(WI,8'h87,8'h00,4'd3), mk(WI,8'h87,8'h00,4'd3), mk(RI,8'h00,8'h00,4'd3),
        mk(WI,8'h07,8'h00,4'd5), mk(RD,8'h00,8'h03,4'd5)
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 base_sel = 1'b0;
    logic [15:0]          io_addr = '0;
    logic                 io_wr = 1'b0;
    logic                 io_rd = 1'b0;
    logic [7:0]           io_wdata = '0;
    logic [7:0]           io_rdata;
    logic [NUM_DEV*8-1:0] dev_rdata;
    logic [NUM_DEV*8-1:0] dev_enable;
    logic [NUM_DEV-1:0]   dev_wr_stb;
    logic [NUM_DEV-1:0]   dev_rd_stb;
    logic [7:0]           dev_reg_idx;
    logic [7:0]           dev_reg_wdata;

    int n_checks = 0;
    int n_err = 0;
    logic [NUM_DEV-1:0] last_wstb;
    logic [NUM_DEV-1:0] last_rstb;
    logic [7:0]         last_idx;
    logic [7:0]         last_wd;
    logic [15:0]        base;
    logic [7:0]         v;

    always #10 clk = ~clk;

    // Function-block model: device d returns 0xA0 + d on banked reads.
    always_comb begin
        for (int d = 0; d < NUM_DEV; d++) dev_rdata[d*8 +: 8] = 8'(8'hA0 + d);
    end

    sio_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_rdata(dev_rdata), .dev_enable(dev_enable), .dev_wr_stb(dev_wr_stb),
        .dev_rd_stb(dev_rd_stb), .dev_reg_idx(dev_reg_idx), .dev_reg_wdata(dev_reg_wdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        last_wstb = dev_wr_stb;
        last_idx  = dev_reg_idx;
        last_wd   = dev_reg_wdata;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] r);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        r = io_rdata;
        last_rstb = dev_rd_stb;
        io_rd = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 / R7: reset state.
        check("R10 reset rdata", 64'(io_rdata), 64'hFF);
        check("R7 reset enables", 64'(|dev_enable), 64'h0);
        check("R8 reset strobes", 64'({dev_wr_stb, dev_rd_stb}), 64'h0);
        rst_n = 1'b1;
        base = 16'h002E;

        // Vector table; covers R2 R3 R4 R5 R6 R7 R8 R9.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] d, e;
            logic [3:0] r;
            {op, d, e, r} = VEC[i];
            case (op)
                WI: bus_wr(base, d);
                WD: bus_wr(base + 16'd1, d);
                RI: begin bus_rd(base, v); check($sformatf("R%0d vec%0d", r, i), 64'(v), 64'(e)); end
                default: begin bus_rd(base + 16'd1, v); check($sformatf("R%0d vec%0d", r, i), 64'(v), 64'(e)); end
            endcase
        end

        // R7: device 3 enable on its byte lane only.
        check("R7 dev3 enable", 64'(dev_enable[3*8 +: 8]), 64'h5A);
        check("R7 other enables", 64'(|(dev_enable & ~({{(NUM_DEV*8-8){1'b0}}, 8'hFF} << 24))), 64'h0);

        // R7: enable write raises no strobe.
        bus_wr(base, 8'h30); bus_wr(base + 16'd1, 8'h5A);
        check("R7 no strobe on enable", 64'(last_wstb), 64'h0);

        // R8: forwarded banked write and read for device 3.
        bus_wr(base, 8'h40); bus_wr(base + 16'd1, 8'hC3);
        check("R8 wr strobe", 64'(last_wstb), 64'h0008);
        check("R8 wr idx", 64'(last_idx), 64'h40);
        check("R8 wr data", 64'(last_wd), 64'hC3);
        @(negedge clk);
        check("R8 strobe one cycle", 64'(dev_wr_stb), 64'h0);
        bus_rd(base + 16'd1, v);
        check("R8 rd data", 64'(v), 64'hA3);
        check("R8 rd strobe", 64'(last_rstb), 64'h0008);

        // R10: idle value in the cycle after a read.
        @(negedge clk);
        check("R10 idle after read", 64'(io_rdata), 64'hFF);

        // R4: locked data write raises no strobe.
        bus_wr(base, 8'hAA);
        bus_wr(base + 16'd1, 8'h11);
        check("R4 locked write strobe", 64'(last_wstb), 64'h0);

        // R1: alternate base strap.
        base_sel = 1'b1;
        bus_wr(16'h002E, 8'h87); bus_wr(16'h002E, 8'h87);
        bus_rd(16'h004E, v);
        check("R1 old base ignored", 64'(v), 64'hFF);
        bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h87);
        bus_rd(16'h004E, v);
        check("R1 index at 0x4E", 64'(v), 64'h00);
        bus_wr(16'h004E, 8'h07);
        bus_rd(16'h004F, v);
        check("R1 data at 0x4F", 64'(v), 64'h03);
        bus_rd(16'h002F, v);
        check("R1 unmapped address", 64'(v), 64'hFF);

        // R5: reset clears the device selector and enables.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 enables after reset", 64'(|dev_enable), 64'h0);
        check("R10 rdata after reset", 64'(io_rdata), 64'hFF);
        rst_n = 1'b1;
        bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h87);
        bus_wr(16'h004E, 8'h07);
        bus_rd(16'h004F, v);
        check("R5 selector after reset", 64'(v), 64'h00);

        summary();
    end

endmodule